// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block works next to a DRAM access controller and decides when refresh cycles must be issued. Out of reset it holds off all traffic for a power-up pause, then asks the controller for a fixed run of initialization cycles. Every one of those cycles is a refresh, so the rule that the run contains at least one refresh always holds. Once that run has been granted, the block declares the memory ready. From then on it raises refresh requests at even spacing, so that every row is refreshed within the retention period.

The controller tells the block when the DRAM is in self-refresh. While it is, the scheduler stays silent. When self-refresh ends, the scheduler demands a burst of one refresh per row and keeps user traffic blocked until the whole burst has been granted. A configuration input picks the refresh kind. In the address-driven kind, the row to refresh comes from a counter kept inside the block. In the strobe-order kind, the device counts rows by itself and the counter is left alone. Refresh slots that the controller has not yet served are queued up to a small limit. A slot that arrives while the queue is full raises a sticky error.

Top module: `dram_refresh_sched`

## Requirements
- R1: During reset, `ready`, `ref_req` and `miss_err` are 0 and `ref_row` is 0.
- R2: After reset is released, `ref_req` stays 0 for exactly PAUSE_CYC clock edges. It first reads 1 after the PAUSE_CYC-th edge.
- R3: After the pause, `ref_req` stays high until INIT_CYC grants have been taken. `ready` stays 0 until then and reads 1 right after the edge that takes the INIT_CYC-th grant.
- R4: A raised `ref_req` stays high until a grant is taken. A `ref_grant` while `ref_req` is 0 has no effect: `ref_row` does not move and no request is consumed.
- R5: While ready, a refresh slot becomes due every IVL = RETENTION_CYC / ROWS cycles. The slots are counted from the edge at which `ready` rose, and their spacing does not depend on when grants arrive.
- R6: `ref_row` advances by one on every taken grant while `ref_kind` is 1 (address-driven refresh). It wraps from ROWS-1 to 0. It does not change on grants while `ref_kind` is 0 (strobe-order refresh).
- R7: `ref_kind` equals `cfg_ras_only`: 1 selects address-driven refresh, 0 selects strobe-order refresh.
- R8: Slots that have not been granted accumulate. `ref_req` stays high until one grant has been taken for each of them, with at most MISS_LIMIT outstanding.
- R9: A slot that falls due while MISS_LIMIT slots are already outstanding, with no grant taken in that cycle, sets `miss_err`. `miss_err` then stays 1 until reset.
- R10: When `sref_active` is 1 while ready, the next edge drops `ready` and `ref_req`. Both stay 0 for as long as `sref_active` stays 1.
- R11: After `sref_active` falls, `ref_req` is held high and `ready` is held at 0 until exactly ROWS grants have been taken. Then `ready` returns and slot pacing restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ras_only | input | 1 | Refresh kind: 1 address-driven, 0 strobe-order |
| sref_active | input | 1 | DRAM is held in self-refresh by the controller |
| ref_grant | input | 1 | Controller has issued the requested refresh |
| ref_req | output | 1 | A refresh cycle is wanted |
| ref_kind | output | 1 | Kind of the wanted refresh (1 address-driven) |
| ref_row | output | $clog2(ROWS) | Row for an address-driven refresh |
| ready | output | 1 | User traffic may proceed |
| miss_err | output | 1 | Sticky: outstanding-slot limit exceeded |

## Verification
The hardest state to reach from the ports is a full queue of outstanding slots followed by one more slot. The limit depends on the controller ignoring requests for several whole intervals, with no grant in the exact cycle of the next slot. The stimulus reaches this by bringing the block up with short parameters and then withholding grants for a counted number of cycles from the edge at which `ready` rose. Because the slot edges are known exactly, the error is checked as still clear just before the overflowing slot and as set just after it. The queue is then drained grant by grant to show its saturated depth. The post-self-refresh burst is reached the same way, with the row counter observed wrapping over a full pass of rows.

// File: rtl/dram_rfs_pkg.sv
package dram_rfs_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_INIT,
    ST_RUN,
    ST_SREF,
    ST_BURST
  } rfs_state_e;

  // Cycles between refresh slots: retention window spread over all rows.
  function automatic int rfs_interval(int retention, int rows);
    int q;
    q = retention / rows;
    if (q < 1) q = 1;
    return q;
  endfunction

  // Outstanding-slot update: add a due slot, remove a served one, clamp.
  function automatic int rfs_pend_next(int pend, bit due, bit served, int limit);
    int n;
    n = pend + (due ? 1 : 0) - (served ? 1 : 0);
    if (n > limit) n = limit;
    if (n < 0) n = 0;
    return n;
  endfunction

  // Row counter step with wrap.
  function automatic int rfs_row_next(int row, int rows);
    return (row >= rows - 1) ? 0 : row + 1;
  endfunction

endpackage

// File: rtl/rfs_pacer.sv
module rfs_pacer
  import dram_rfs_pkg::*;
#(
  parameter int RETENTION_CYC = 3200000,
  parameter int ROWS          = 4096,
  parameter int MISS_LIMIT    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic take,
  output logic pend_nz,
  output logic miss_err
);

  localparam int IVL = rfs_interval(RETENTION_CYC, ROWS);
  localparam int IW  = $clog2(IVL + 1);
  localparam int DW  = $clog2(MISS_LIMIT + 1);

  logic [IW-1:0] tcnt;
  logic [DW-1:0] pend;
  logic          slot_due;
  logic          over_evt;

  assign slot_due = run_en && (tcnt == IW'(IVL - 1));
  assign over_evt = slot_due && !take && (pend == DW'(MISS_LIMIT));
  assign pend_nz  = (pend != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt     <= '0;
      pend     <= '0;
      miss_err <= 1'b0;
    end else begin
      if (!run_en) begin
        tcnt <= '0;
        pend <= '0;
      end else begin
        tcnt <= slot_due ? '0 : tcnt + 1'b1;
        pend <= DW'(rfs_pend_next(int'(pend), slot_due, take, MISS_LIMIT));
      end
      if (over_evt) miss_err <= 1'b1;
    end
  end

  // R9: the queue never holds more than the limit
  p_pend_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= DW'(MISS_LIMIT));

  // R9: the error flag is sticky
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    miss_err |=> miss_err);

  // R5: a due slot always leaves something outstanding
  p_slot_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    slot_due |=> pend_nz);

endmodule

// File: rtl/rfs_row_ctr.sv
module rfs_row_ctr
  import dram_rfs_pkg::*;
#(
  parameter int ROWS = 4096
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step,
  output logic [$clog2(ROWS)-1:0] row
);

  localparam int RW = $clog2(ROWS);

  always_ff @(posedge clk) begin
    if (!rst_n) row <= '0;
    else if (step) row <= RW'(rfs_row_next(int'(row), ROWS));
  end

  // R6: the row index stays inside the array
  p_row_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(row) < ROWS);

endmodule

// File: rtl/rfs_seq.sv
module rfs_seq
  import dram_rfs_pkg::*;
#(
  parameter int PAUSE_CYC = 10000,
  parameter int INIT_CYC  = 8,
  parameter int ROWS      = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sref_active,
  input  logic accept,
  input  logic pend_nz,
  output logic seq_req,
  output logic run_en,
  output logic ready
);

  localparam int PW   = $clog2(PAUSE_CYC + 1);
  localparam int SMAX = (INIT_CYC > ROWS) ? INIT_CYC : ROWS;
  localparam int SW   = $clog2(SMAX + 1);

  rfs_state_e    state;
  logic [PW-1:0] pcnt;
  logic [SW-1:0] scnt;
  logic          pause_done;
  logic          init_done;
  logic          burst_done;

  assign pause_done = (state == ST_PAUSE) && (pcnt == PW'(PAUSE_CYC - 1));
  assign init_done  = (state == ST_INIT)  && accept && (scnt == SW'(INIT_CYC - 1));
  assign burst_done = (state == ST_BURST) && accept && (scnt == SW'(ROWS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_PAUSE;
      pcnt  <= '0;
      scnt  <= '0;
    end else begin
      unique case (state)
        ST_PAUSE: begin
          if (pause_done) begin
            state <= ST_INIT;
            scnt  <= '0;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        ST_INIT: begin
          if (init_done) state <= ST_RUN;
          else if (accept) scnt <= scnt + 1'b1;
        end
        ST_RUN: begin
          if (sref_active) state <= ST_SREF;
        end
        ST_SREF: begin
          if (!sref_active) begin
            state <= ST_BURST;
            scnt  <= '0;
          end
        end
        ST_BURST: begin
          if (burst_done) state <= ST_RUN;
          else if (accept) scnt <= scnt + 1'b1;
        end
        default: state <= ST_PAUSE;
      endcase
    end
  end

  assign run_en  = (state == ST_RUN);
  assign ready   = run_en;
  assign seq_req = (state == ST_INIT) || (state == ST_BURST) || (run_en && pend_nz);

  // R3 / R11: traffic is released only by a taken grant
  p_ready_by_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(accept));

  // R10: self-refresh while ready silences the block on the next edge
  p_sref_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ready && sref_active |=> !ready && !seq_req);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_rfs_pkg::*;
#(
  parameter int PAUSE_CYC     = 10000,
  parameter int INIT_CYC      = 8,
  parameter int ROWS          = 4096,
  parameter int RETENTION_CYC = 3200000,
  parameter int MISS_LIMIT    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_ras_only,
  input  logic                    sref_active,
  input  logic                    ref_grant,
  output logic                    ref_req,
  output logic                    ref_kind,
  output logic [$clog2(ROWS)-1:0] ref_row,
  output logic                    ready,
  output logic                    miss_err
);

  logic grant_ok;
  logic run_en;
  logic pend_nz;
  logic row_step;
  logic run_take;

  assign grant_ok = ref_grant && ref_req;
  assign run_take = grant_ok && run_en;
  assign row_step = grant_ok && cfg_ras_only;
  assign ref_kind = cfg_ras_only;

  rfs_seq #(
    .PAUSE_CYC(PAUSE_CYC),
    .INIT_CYC (INIT_CYC),
    .ROWS     (ROWS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .sref_active(sref_active),
    .accept     (grant_ok),
    .pend_nz    (pend_nz),
    .seq_req    (ref_req),
    .run_en     (run_en),
    .ready      (ready)
  );

  rfs_pacer #(
    .RETENTION_CYC(RETENTION_CYC),
    .ROWS         (ROWS),
    .MISS_LIMIT   (MISS_LIMIT)
  ) u_pacer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .take    (run_take),
    .pend_nz (pend_nz),
    .miss_err(miss_err)
  );

  rfs_row_ctr #(
    .ROWS(ROWS)
  ) u_row (
    .clk  (clk),
    .rst_n(rst_n),
    .step (row_step),
    .row  (ref_row)
  );

  // R4: a request is withdrawn only by a grant (or self-refresh entry)
  p_hold_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req && !ref_grant && !sref_active |=> ref_req);

  // R4 / R6: the row only moves on a taken address-driven grant
  p_row_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_grant && ref_req && ref_kind) |=> $stable(ref_row));

endmodule

// File: tb/tb_dram_refresh_sched.sv
module tb_dram_refresh_sched;

  localparam int PAUSE = 20;
  localparam int INIT  = 8;
  localparam int ROWS  = 8;
  localparam int RET   = 128;
  localparam int IVL   = RET / ROWS;
  localparam int LIM   = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_ras_only = 1'b0;
  logic       sref_active = 1'b0;
  logic       ref_grant = 1'b0;
  logic       ref_req;
  logic       ref_kind;
  logic [2:0] ref_row;
  logic       ready;
  logic       miss_err;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  dram_refresh_sched #(
    .PAUSE_CYC(PAUSE), .INIT_CYC(INIT), .ROWS(ROWS),
    .RETENTION_CYC(RET), .MISS_LIMIT(LIM)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cfg_ras_only(cfg_ras_only),
    .sref_active(sref_active), .ref_grant(ref_grant),
    .ref_req(ref_req), .ref_kind(ref_kind), .ref_row(ref_row),
    .ready(ready), .miss_err(miss_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic grant_one();
    int guard = 0;
    while (!ref_req && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    ref_grant = 1'b1;
    @(negedge clk);
    ref_grant = 1'b0;
  endtask

  task automatic count_to_req(output int k);
    k = 0;
    while (!ref_req && k < 1000) begin
      @(negedge clk);
      k++;
    end
  endtask

  // R1, R2, R3, R6 wrap: reset and bring-up; returns at negedge after ready rose
  task automatic bring_up(input bit kind);
    int k;
    rst_n = 1'b0;
    sref_active = 1'b0;
    ref_grant = 1'b0;
    cfg_ras_only = kind;
    cycles(3);
    chk(!ready && !ref_req && !miss_err && ref_row == 0, "R1 reset outputs",
        {ready, ref_req, miss_err}, 0);
    rst_n = 1'b1;
    count_to_req(k);
    chk(k == PAUSE, "R2 pause length", k, PAUSE);
    for (int g = 0; g < INIT - 1; g++) grant_one();
    chk(!ready && ref_req, "R3 not ready before last init grant", ready, 0);
    if (kind) chk(ref_row == 3'(INIT - 1), "R6 row during init", ref_row, INIT - 1);
    grant_one();
    chk(ready == 1'b1, "R3 ready after init run", ready, 1);
    if (kind) chk(ref_row == 3'(INIT % ROWS), "R6 row wrap", ref_row, INIT % ROWS);
  endtask

  task automatic t_reset_and_init();
    bring_up(1'b0);
    chk(ref_row == 0, "R6 no step in strobe-order init", ref_row, 0);
    chk(ref_kind == 1'b0, "R7 kind strobe-order", ref_kind, 0);
    cfg_ras_only = 1'b1;
    #1;
    chk(ref_kind == 1'b1, "R7 kind address-driven", ref_kind, 1);
  endtask

  task automatic t_pacing();
    int k;
    bring_up(1'b1);
    count_to_req(k);
    chk(k == IVL, "R5 first slot", k, IVL);
    cycles(3);
    chk(ref_req == 1'b1 && ref_row == 0, "R4 request held without grant", ref_req, 1);
    grant_one();
    chk(ref_row == 1 && !ref_req, "R6 row step on grant", ref_row, 1);
    count_to_req(k);
    chk(k == IVL - 4, "R5 slot spacing fixed", k, IVL - 4);
    cfg_ras_only = 1'b0;
    grant_one();
    chk(ref_row == 1, "R6 strobe-order grant leaves row", ref_row, 1);
    cfg_ras_only = 1'b1;
    ref_grant = 1'b1;
    @(negedge clk);
    ref_grant = 1'b0;
    chk(ref_row == 1 && !ref_req, "R4 stray grant ignored", ref_row, 1);
    count_to_req(k);
    chk(k == IVL - 2, "R4 stray grant consumed nothing", k, IVL - 2);
    grant_one();
    chk(ref_row == 2, "R6 row after next grant", ref_row, 2);
  endtask

  task automatic t_overflow();
    bring_up(1'b1);
    cycles(LIM * IVL);
    chk(!miss_err && ref_req, "R9 no error at full queue", miss_err, 0);
    cycles(IVL);
    chk(miss_err == 1'b1, "R9 error on extra slot", miss_err, 1);
    for (int g = 0; g < LIM - 1; g++) grant_one();
    chk(ref_req == 1'b1, "R8 outstanding slots kept", ref_req, 1);
    grant_one();
    chk(ref_req == 1'b0, "R8 queue drained at limit", ref_req, 0);
    chk(ref_row == 3'(LIM), "R6 row after drain", ref_row, LIM);
    cycles(5);
    chk(miss_err == 1'b1, "R9 error sticky", miss_err, 1);
  endtask

  task automatic t_self_refresh();
    int k;
    int bad;
    bring_up(1'b1);
    sref_active = 1'b1;
    @(negedge clk);
    bad = 0;
    for (int i = 0; i < 3 * IVL; i++) begin
      if (ready || ref_req) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R10 quiet in self-refresh", bad, 0);
    sref_active = 1'b0;
    @(negedge clk);
    chk(ref_req && !ready, "R11 burst starts", ready, 0);
    for (int g = 0; g < ROWS - 1; g++) grant_one();
    chk(!ready && ref_req, "R11 held until full burst", ready, 0);
    chk(ref_row == 3'(ROWS - 1), "R6 row in burst", ref_row, ROWS - 1);
    grant_one();
    chk(ready && !ref_req, "R11 ready after burst", ready, 1);
    chk(ref_row == 0, "R6 wrap after burst", ref_row, 0);
    count_to_req(k);
    chk(k == IVL, "R11 pacing restarts", k, IVL);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_and_init();
    t_pacing();
    t_overflow();
    t_self_refresh();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule